// File: doc/BRIEF.md
# Pipelined Cascadable ALU Slice

This block is a 16-bit arithmetic/logic slice. Two operand inputs are captured in their own registers, and each register has a load enable that is active low. An operand-select stage then picks the two ALU inputs from the A operand, the B operand, the stored result or zero. The core performs one of eight functions: three add/subtract forms that use a carry input, three bitwise forms, and two constants. A result register with its own active-low load enable captures the output.

The input register stage and the output register stage each have a bypass control, so one slice can run fully pipelined, fully flow-through, or partly registered. Feeding the stored result back as an operand turns the slice into an accumulator.

Wider words are built by chaining slices. The carry output of one slice drives the carry input of the next more significant slice. For an external lookahead generator, each slice also reports an active-low group propagate and group generate. The overflow and zero flags are taken from the combinational ALU result. An active-low output enable controls whether the result port is driven.

Top module: `alu_slice`

## Requirements
- R1: A synchronous reset with rst_n low clears the A, B and result registers to zero. After reset, with no bypass, the registered result reads 0.
- R2: An input register loads its operand on a clock edge only when its load enable (a_load_n, b_load_n) is low. Otherwise it holds its value.
- R3: When in_bypass is 1, a_in and b_in reach the operand select directly. When it is 0, the registered values are used.
- R4: The result register loads on a clock edge when f_load_n is low. When out_bypass is 0, f_out shows the register. When out_bypass is 1, f_out shows the combinational result.
- R5: src_sel selects the (R, S) operands as follows: 0 gives (A, stored result), 1 gives (A, 0), 2 gives (0, B), 3 gives (A, B).
- R6: op_sel selects the non-arithmetic functions as follows: 0 gives all zeros, 4 gives R^S, 5 gives R|S, 6 gives R&S, 7 gives all ones.
- R7: op_sel selects the arithmetic functions as follows: 1 gives S+~R+carry_in, 2 gives R+~S+carry_in, 3 gives R+S+carry_in.
- R8: carry_out is the carry from the top bit of an arithmetic function and is 0 for the other codes. Two slices joined carry_out to carry_in form a correct 32-bit result.
- R9: ovf is 1 on two's-complement overflow of an arithmetic function and is 0 for every other code.
- R10: zero is 1 exactly when the combinational result is 0, whatever the result register holds.
- R11: For arithmetic codes, prop_n is low when every bit position propagates, and gen_n is low when the addends produce a carry with no carry input. For the other codes both are high.
- R12: When f_out_en_n is high, f_drive is 0 and f_out reads 0. When it is low, f_drive is 1 and f_out carries the result.
- R13: The fed-back operand always comes from the result register output, so each accumulate step with the result bypassed gives the previous stored value plus A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 16 | A operand |
| b_in | input | 16 | B operand |
| a_load_n | input | 1 | A register load, active low |
| b_load_n | input | 1 | B register load, active low |
| f_load_n | input | 1 | Result register load, active low |
| in_bypass | input | 1 | Bypass both input registers |
| out_bypass | input | 1 | Bypass the result register |
| src_sel | input | 2 | Operand select |
| op_sel | input | 3 | Function select |
| carry_in | input | 1 | Carry from the less significant slice |
| f_out_en_n | input | 1 | Result port enable, active low |
| f_out | output | 16 | Result, 0 when not driven |
| f_drive | output | 1 | Result port is driven |
| carry_out | output | 1 | Carry to the more significant slice |
| prop_n | output | 1 | Group propagate, active low |
| gen_n | output | 1 | Group generate, active low |
| ovf | output | 1 | Two's-complement overflow |
| zero | output | 1 | Result is zero |

## Verification
The assertions assume that every control input is driven to a known level on every clock edge after reset. The hold check on the result register also assumes that out_bypass and the output enable stay unchanged across the edge it inspects. The bench changes all inputs just after a rising edge and samples at the falling edge, so each edge sees stable values. The bench also keeps a known control setting in every cycle, including the cycles where reset is asserted.

// File: rtl/alu_slice_pkg.sv
// Package: operand-select and function codes shared by the ALU slice.
// Assumes the decode values below are fixed; neighbouring slices and
// control logic rely on the same encodings.
package alu_slice_pkg;

    typedef enum logic [1:0] {
        SRC_A_FB   = 2'd0,
        SRC_A_ZERO = 2'd1,
        SRC_ZERO_B = 2'd2,
        SRC_A_B    = 2'd3
    } src_sel_e;

    typedef enum logic [2:0] {
        OP_CLEAR = 3'd0,
        OP_S_M_R = 3'd1,
        OP_R_M_S = 3'd2,
        OP_ADD   = 3'd3,
        OP_XOR   = 3'd4,
        OP_OR    = 3'd5,
        OP_AND   = 3'd6,
        OP_SET   = 3'd7
    } alu_op_e;

    function automatic logic op_is_arith(input logic [2:0] op);
        return (op == OP_S_M_R) || (op == OP_R_M_S) || (op == OP_ADD);
    endfunction

endpackage

// File: rtl/alu_stage_reg.sv
// Module: one pipeline register of the slice with an active-low load
// enable and a synchronous active-low clear. Any bypass multiplexing is
// done by the parent, so this module only ever shows the stored value.
module alu_stage_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture d when load_n is low; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (!load_n)
            q <= d;
    end

endmodule

// File: rtl/alu_operand_sel.sv
// Module: operand-select matrix. It chooses the R and S inputs of the
// core from the A operand, the B operand, the stored result and zero.
// Assumes fb is taken from a register output, so no combinational loop
// can form through this stage.
module alu_operand_sel
    import alu_slice_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [1:0]   src_sel,
    input  logic [W-1:0] a_op,
    input  logic [W-1:0] b_op,
    input  logic [W-1:0] fb,
    output logic [W-1:0] r_op,
    output logic [W-1:0] s_op
);

    // Decode the select code into the operand pair.
    always_comb begin
        unique case (src_sel_e'(src_sel))
            SRC_A_FB:   begin r_op = a_op; s_op = fb;   end
            SRC_A_ZERO: begin r_op = a_op; s_op = '0;   end
            SRC_ZERO_B: begin r_op = '0;   s_op = b_op; end
            default:    begin r_op = a_op; s_op = b_op; end
        endcase
    end

endmodule

// File: rtl/alu_func_core.sv
// Module: eight-function ALU core with group lookahead outputs. Each
// arithmetic code is formed as x + y + cin, with one operand inverted
// for the subtract forms. Propagate and generate are active low and are
// held high for the non-arithmetic codes.
module alu_func_core
    import alu_slice_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] r_op,
    input  logic [W-1:0] s_op,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         ovf,
    output logic         prop_n,
    output logic         gen_n
);

    localparam int MSB = W - 1;

    logic [W-1:0] add_x, add_y, add_sum;
    logic         arith;
    logic         grp_p, grp_g;

    assign arith = op_is_arith(op_sel);

    // Pick the addend pair for the arithmetic forms.
    always_comb begin
        unique case (alu_op_e'(op_sel))
            OP_S_M_R: begin add_x = ~r_op; add_y = s_op;  end
            OP_R_M_S: begin add_x = r_op;  add_y = ~s_op; end
            OP_ADD:   begin add_x = r_op;  add_y = s_op;  end
            default:  begin add_x = '0;    add_y = '0;    end
        endcase
    end

    // Fold per-bit propagate/generate into the group terms, low to high.
    always_comb begin
        grp_p = 1'b1;
        grp_g = 1'b0;
        for (int i = 0; i < W; i++) begin
            grp_g = (add_x[i] & add_y[i]) | ((add_x[i] | add_y[i]) & grp_g);
            grp_p = grp_p & (add_x[i] | add_y[i]);
        end
    end

    assign add_sum = add_x + add_y + {{(W-1){1'b0}}, cin};

    // Select the function result.
    always_comb begin
        unique case (alu_op_e'(op_sel))
            OP_CLEAR: res = '0;
            OP_XOR:   res = r_op ^ s_op;
            OP_OR:    res = r_op | s_op;
            OP_AND:   res = r_op & s_op;
            OP_SET:   res = '1;
            default:  res = add_sum;
        endcase
    end

    // Carry, overflow and lookahead outputs, active only for arithmetic codes.
    always_comb begin
        cout   = arith & (grp_g | (grp_p & cin));
        ovf    = arith & (add_x[MSB] == add_y[MSB]) & (add_sum[MSB] != add_x[MSB]);
        prop_n = ~(arith & grp_p);
        gen_n  = ~(arith & grp_g);
    end

endmodule

// File: rtl/alu_slice.sv
// Module: top of the cascadable ALU slice. It contains the input
// registers with a shared bypass, the operand select, the function core,
// and a result register with its own bypass. The flags come from the
// combinational result. The output enable is modelled as a drive flag,
// and the data reads 0 when the port is not driven.
module alu_slice
    import alu_slice_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         a_load_n,
    input  logic         b_load_n,
    input  logic         f_load_n,
    input  logic         in_bypass,
    input  logic         out_bypass,
    input  logic [1:0]   src_sel,
    input  logic [2:0]   op_sel,
    input  logic         carry_in,
    input  logic         f_out_en_n,
    output logic [W-1:0] f_out,
    output logic         f_drive,
    output logic         carry_out,
    output logic         prop_n,
    output logic         gen_n,
    output logic         ovf,
    output logic         zero
);

    localparam int NOPS = 2;

    logic [W-1:0] op_d [NOPS];
    logic [W-1:0] op_q [NOPS];
    logic [W-1:0] op_eff [NOPS];
    logic [NOPS-1:0] op_load_n;
    logic [W-1:0] r_op, s_op, alu_res, f_q, f_sel;

    assign op_d[0]   = a_in;
    assign op_d[1]   = b_in;
    assign op_load_n = {b_load_n, a_load_n};

    // One register plus bypass multiplexer per operand.
    for (genvar g = 0; g < NOPS; g++) begin : g_in_stage
        alu_stage_reg #(.W(W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_n (op_load_n[g]),
            .d      (op_d[g]),
            .q      (op_q[g])
        );
        assign op_eff[g] = in_bypass ? op_d[g] : op_q[g];
    end

    alu_operand_sel #(.W(W)) u_sel (
        .src_sel (src_sel),
        .a_op    (op_eff[0]),
        .b_op    (op_eff[1]),
        .fb      (f_q),
        .r_op    (r_op),
        .s_op    (s_op)
    );

    alu_func_core #(.W(W)) u_core (
        .op_sel (op_sel),
        .r_op   (r_op),
        .s_op   (s_op),
        .cin    (carry_in),
        .res    (alu_res),
        .cout   (carry_out),
        .ovf    (ovf),
        .prop_n (prop_n),
        .gen_n  (gen_n)
    );

    alu_stage_reg #(.W(W)) u_f_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (f_load_n),
        .d      (alu_res),
        .q      (f_q)
    );

    // Choose between the stored and the combinational result, then gate by the enable.
    always_comb begin
        f_sel   = out_bypass ? alu_res : f_q;
        f_drive = ~f_out_en_n;
        f_out   = f_out_en_n ? '0 : f_sel;
        zero    = (alu_res == '0);
    end

endmodule

// File: rtl/alu_slice_chk.sv
// Checker: port-level temporal properties of alu_slice, attached by bind.
// Assumes the controls are at known levels on every edge after reset.
module alu_slice_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   op_sel,
    input logic         out_bypass,
    input logic         f_load_n,
    input logic         f_out_en_n,
    input logic [W-1:0] f_out,
    input logic         f_drive,
    input logic         ovf,
    input logic         zero,
    input logic         prop_n,
    input logic         gen_n
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) && !out_bypass && !f_out_en_n |-> f_out == '0);

    // R4
    f_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(f_load_n) && !out_bypass && $past(!out_bypass)
        && !f_out_en_n && $past(!f_out_en_n) |-> $stable(f_out));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_sel inside {3'd1, 3'd2, 3'd3}) |-> !ovf);

    // R10
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_bypass && !f_out_en_n |-> zero == (f_out == '0));

    // R11
    lookahead_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_sel inside {3'd1, 3'd2, 3'd3}) |-> prop_n && gen_n);

    // R12
    port_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_out_en_n |-> !f_drive && f_out == '0);

endmodule

bind alu_slice alu_slice_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_sel     (op_sel),
    .out_bypass (out_bypass),
    .f_load_n   (f_load_n),
    .f_out_en_n (f_out_en_n),
    .f_out      (f_out),
    .f_drive    (f_drive),
    .ovf        (ovf),
    .zero       (zero),
    .prop_n     (prop_n),
    .gen_n      (gen_n)
);

// File: tb/alu_slice_tb.sv
`timescale 1ns/1ps
module alu_slice_tb;

    typedef struct packed {
        logic [31:0] f;
        logic        drv;
        logic        cout;
        logic        ovf;
        logic        zero;
        logic        pn;
        logic        gn;
    } obs_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_in = '0, b_in = '0;
    logic        a_load_n = 1'b1, b_load_n = 1'b1, f_load_n = 1'b1;
    logic        in_bypass = 1'b0, out_bypass = 1'b0;
    logic [1:0]  src_sel = 2'd3;
    logic [2:0]  op_sel = 3'd0;
    logic        cin = 1'b0, oe_n = 1'b0;

    logic [15:0] f_lo, f_hi;
    logic        drv_lo, drv_hi, c_mid, c_top;
    logic        pn_lo, gn_lo, ovf_lo, pn_hi, gn_hi, ovf_hi, z_lo, z_hi;

    int total = 0, bad = 0;
    bit done = 0;
    logic [31:0] ma = '0, mb = '0, mf = '0;
    obs_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    alu_slice #(.W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in[15:0]), .b_in(b_in[15:0]),
        .a_load_n(a_load_n), .b_load_n(b_load_n), .f_load_n(f_load_n),
        .in_bypass(in_bypass), .out_bypass(out_bypass), .src_sel(src_sel),
        .op_sel(op_sel), .carry_in(cin), .f_out_en_n(oe_n), .f_out(f_lo),
        .f_drive(drv_lo), .carry_out(c_mid), .prop_n(pn_lo), .gen_n(gn_lo),
        .ovf(ovf_lo), .zero(z_lo));

    alu_slice #(.W(16)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .a_in(a_in[31:16]), .b_in(b_in[31:16]),
        .a_load_n(a_load_n), .b_load_n(b_load_n), .f_load_n(f_load_n),
        .in_bypass(in_bypass), .out_bypass(out_bypass), .src_sel(src_sel),
        .op_sel(op_sel), .carry_in(c_mid), .f_out_en_n(oe_n), .f_out(f_hi),
        .f_drive(drv_hi), .carry_out(c_top), .prop_n(pn_hi), .gen_n(gn_hi),
        .ovf(ovf_hi), .zero(z_hi));

    // Driver: apply one cycle of stimulus and push the expected outputs.
    task automatic step(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic la_n, input logic lb_n, input logic lf_n,
                        input logic inb, input logic outb, input logic [1:0] src,
                        input logic [2:0] op, input logic c, input logic en_n);
        logic [31:0] ae, be, r, s, x, y, res;
        logic [32:0] sum;
        logic [16:0] hsum;
        logic        arith;
        obs_t        e;
        @(posedge clk);
        #1;
        a_in = a; b_in = b; a_load_n = la_n; b_load_n = lb_n; f_load_n = lf_n;
        in_bypass = inb; out_bypass = outb; src_sel = src; op_sel = op;
        cin = c; oe_n = en_n;
        ae = inb ? a : ma;
        be = inb ? b : mb;
        case (src)
            2'd0:    begin r = ae;  s = mf;  end
            2'd1:    begin r = ae;  s = '0;  end
            2'd2:    begin r = '0;  s = be;  end
            default: begin r = ae;  s = be;  end
        endcase
        arith = (op == 3'd1) || (op == 3'd2) || (op == 3'd3);
        case (op)
            3'd1:    begin x = ~r; y = s;  end
            3'd2:    begin x = r;  y = ~s; end
            3'd3:    begin x = r;  y = s;  end
            default: begin x = '0; y = '0; end
        endcase
        sum  = {1'b0, x} + {1'b0, y} + {32'd0, c};
        hsum = {1'b0, x[31:16]} + {1'b0, y[31:16]};
        case (op)
            3'd0:    res = '0;
            3'd4:    res = r ^ s;
            3'd5:    res = r | s;
            3'd6:    res = r & s;
            3'd7:    res = '1;
            default: res = sum[31:0];
        endcase
        e.f    = en_n ? 32'd0 : (outb ? res : mf);
        e.drv  = !en_n;
        e.cout = arith & sum[32];
        e.ovf  = arith & (x[31] == y[31]) & (sum[31] != x[31]);
        e.zero = (res == 32'd0);
        e.pn   = arith ? ~(&(x[31:16] | y[31:16])) : 1'b1;
        e.gn   = arith ? ~hsum[16] : 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (!la_n) ma = a;
        if (!lb_n) mb = b;
        if (!lf_n) mf = res;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        ma = '0; mb = '0; mf = '0;
    endtask

    // Monitor: compare observed outputs with the queued expectation mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                obs_t  e, o;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                o.f = {f_hi, f_lo};
                o.drv = drv_lo & drv_hi;
                o.cout = c_top;
                o.ovf = ovf_hi;
                o.zero = z_lo & z_hi;
                o.pn = pn_hi;
                o.gn = gn_hi;
                total++;
                if (o !== e) begin
                    bad++;
                    $display("FAIL %s: f=%h drv=%b c=%b v=%b z=%b p=%b g=%b expected f=%h drv=%b c=%b v=%b z=%b p=%b g=%b",
                             t, o.f, o.drv, o.cout, o.ovf, o.zero, o.pn, o.gn,
                             e.f, e.drv, e.cout, e.ovf, e.zero, e.pn, e.gn);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #100us;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: registers read zero after reset
        step("R1", 32'h1234_5678, 32'h9abc_def0, 1, 1, 1, 0, 0, 2'd3, 3'd3, 0, 0);
        step("R1", 32'h1234_5678, 32'h9abc_def0, 1, 1, 1, 0, 1, 2'd3, 3'd3, 0, 0);
        // R2: load the input registers, then hold them while inputs change
        step("R2", 32'h0001_0005, 32'h0000_0003, 0, 0, 1, 0, 1, 2'd3, 3'd3, 0, 0);
        step("R2", 32'hffff_ffff, 32'hffff_ffff, 1, 1, 1, 0, 1, 2'd3, 3'd3, 0, 0);
        step("R2", 32'h0000_0000, 32'h0000_0000, 1, 0, 1, 0, 1, 2'd3, 3'd5, 0, 0);
        // R3 and R8: bypassed inputs with a carry across the slice boundary
        step("R3", 32'h0000_ffff, 32'h0000_0001, 1, 1, 1, 1, 1, 2'd3, 3'd3, 0, 0);
        step("R8", 32'hffff_ffff, 32'h0000_0000, 1, 1, 1, 1, 1, 2'd3, 3'd3, 1, 0);
        // R7: the three arithmetic forms
        step("R7", 32'h0000_000a, 32'h0000_0003, 1, 1, 1, 1, 1, 2'd3, 3'd2, 1, 0);
        step("R7", 32'h0000_000a, 32'h0000_0003, 1, 1, 1, 1, 1, 2'd3, 3'd1, 1, 0);
        step("R7", 32'h1234_0000, 32'h0000_4321, 1, 1, 1, 1, 1, 2'd3, 3'd3, 1, 0);
        step("R7", 32'h0000_0005, 32'h0000_0005, 1, 1, 1, 1, 1, 2'd3, 3'd2, 0, 0);
        // R6 and R11: logic and constant codes keep the lookahead outputs idle
        step("R6", 32'hf0f0_1234, 32'h0ff0_ffff, 1, 1, 1, 1, 1, 2'd3, 3'd4, 1, 0);
        step("R6", 32'hf0f0_1234, 32'h0ff0_0000, 1, 1, 1, 1, 1, 2'd3, 3'd5, 1, 0);
        step("R6", 32'hf0f0_1234, 32'h0ff0_ff00, 1, 1, 1, 1, 1, 2'd3, 3'd6, 1, 0);
        step("R6", 32'hffff_ffff, 32'hffff_ffff, 1, 1, 1, 1, 1, 2'd3, 3'd0, 1, 0);
        step("R11", 32'h0000_0000, 32'h0000_0000, 1, 1, 1, 1, 1, 2'd3, 3'd7, 1, 0);
        // R11: propagate and generate for arithmetic codes
        step("R11", 32'hffff_0000, 32'h0000_0000, 1, 1, 1, 1, 1, 2'd3, 3'd3, 0, 0);
        step("R11", 32'h8000_0000, 32'h8000_0000, 1, 1, 1, 1, 1, 2'd3, 3'd3, 0, 0);
        // R5: operand select codes 1 and 2
        step("R5", 32'h0000_0011, 32'h0000_0022, 1, 1, 1, 1, 1, 2'd1, 3'd3, 0, 0);
        step("R5", 32'h0000_0011, 32'h0000_0022, 1, 1, 1, 1, 1, 2'd2, 3'd3, 0, 0);
        // R4: result register shows the old value, then the loaded value
        step("R4", 32'h0000_0100, 32'h0000_0023, 1, 1, 0, 1, 0, 2'd3, 3'd3, 0, 0);
        step("R4", 32'h0000_0000, 32'h0000_0000, 1, 1, 1, 1, 0, 2'd3, 3'd3, 0, 0);
        // R10: zero flag follows the combinational result, not the register
        step("R10", 32'h0000_0777, 32'h0000_0777, 1, 1, 1, 1, 0, 2'd3, 3'd2, 1, 0);
        // R13: accumulate through the stored result with the output bypassed
        step("R13", 32'h0000_0005, 32'h0000_0000, 1, 1, 0, 1, 1, 2'd0, 3'd3, 0, 0);
        step("R13", 32'h0000_0005, 32'h0000_0000, 1, 1, 0, 1, 1, 2'd0, 3'd3, 0, 0);
        step("R13", 32'h0000_0005, 32'h0000_0000, 1, 1, 0, 1, 1, 2'd0, 3'd3, 0, 0);
        // R9: overflow on add and on subtract
        step("R9", 32'h7fff_ffff, 32'h0000_0001, 1, 1, 1, 1, 1, 2'd3, 3'd3, 0, 0);
        step("R9", 32'h8000_0000, 32'h0000_0001, 1, 1, 1, 1, 1, 2'd3, 3'd2, 1, 0);
        step("R9", 32'hffff_ffff, 32'h0000_0001, 1, 1, 1, 1, 1, 2'd3, 3'd3, 0, 0);
        // R12: port disabled, then enabled again
        step("R12", 32'h0000_1111, 32'h0000_2222, 1, 1, 1, 1, 1, 2'd3, 3'd3, 0, 1);
        step("R12", 32'h0000_1111, 32'h0000_2222, 1, 1, 1, 1, 1, 2'd3, 3'd3, 0, 0);
        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule